// File: doc/BRIEF.md
# I2C Master SCL Timing Generator

This block produces the serial clock waveform of an I2C bus master. A programmable prescaler divides the functional clock into an internal tick. Two segment counters then size the low and high halves of every SCL period in ticks. The low half carries a fixed extra of seven ticks and the high half a fixed extra of five ticks.

Each timing word holds two byte fields. The low byte is used for standard and fast operation, and for the first (master-code) phase of a high-speed transfer. The high byte is used for the second high-speed phase. During the second phase the prescaler is skipped and the tick runs at the functional clock rate.

A controller starts the generator with a run request. It moves a high-speed transfer into its second phase with a one-cycle strobe. Data and bit control use the tick, the change strobe (SCL has just fallen) and the sample strobe (middle of SCL high).

Top module: `scl_timing_gen`

## Requirements
- R1: While running in standard/fast timing with prescaler value P, `tick_o` pulses once every P+1 functional clock cycles.
- R2: Each SCL low period lasts (selected low field + 7) ticks, which is (L+7)*(P+1) clock cycles in standard/fast timing.
- R3: Each SCL high period lasts (selected high field + 5) ticks, which is (H+5)*(P+1) clock cycles in standard/fast timing.
- R4: Timing bits 7:0 are used when `hs_en_i` is 0 or before the phase strobe. Bits 15:8 are used after `hs_go_i` is pulsed with `hs_en_i` at 1. The strobe has no effect while `hs_en_i` is 0. Stopping returns the block to bits 7:0.
- R5: When `run_i` goes low, `scl_o` is high from the next cycle on, and no tick, change or sample pulse occurs while stopped. A restart begins with a complete low period.
- R6: In the second high-speed phase, `tick_o` pulses on every clock cycle whatever the prescaler value, so the low period lasts L+7 cycles and the high period H+5 cycles.
- R7: `change_o` is high for exactly the first cycle of every SCL low period. `sample_o` pulses once per high period, on tick number floor((H+5)/2), counting from zero.
- R8: A change to a timing word, or to the phase, made during a period leaves that period unchanged and applies from the start of the next low period.
- R9: Under reset, `scl_o` is 1 and `tick_o`, `change_o` and `sample_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| presc_i | input | 8 (PSC_W) | Prescaler value P; tick period is P+1 clocks |
| low_cfg_i | input | 16 (2*FIELD_W) | Low-time word: [7:0] standard/fast, [15:8] high-speed |
| high_cfg_i | input | 16 (2*FIELD_W) | High-time word: [7:0] standard/fast, [15:8] high-speed |
| hs_en_i | input | 1 | High-speed operation enable |
| run_i | input | 1 | 1 generates SCL, 0 stops and releases it |
| hs_go_i | input | 1 | One-cycle strobe that enters the second high-speed phase |
| scl_o | output | 1 | SCL drive, 1 = released high, 0 = pulled low |
| tick_o | output | 1 | Internal tick pulse |
| sample_o | output | 1 | Pulse at the middle of SCL high |
| change_o | output | 1 | Pulse on the first cycle of SCL low |

## Verification
Several prescaler and field pairs are used, including all-zero fields with P=0. These separate the +7 offset from the +5 offset, and the prescale factor from the field value. A high-speed run with distinct low and high bytes shows whether the byte selection and the prescaler bypass change together at the phase strobe. The same strobe with high-speed disabled shows that it is ignored. Timing words rewritten just after a falling edge, and stops in the middle of a low period, show whether new values wait for the next low period and whether a restart reloads the counters.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

   typedef enum logic [1:0] {
      SEG_IDLE = 2'd0,
      SEG_LOW  = 2'd1,
      SEG_HIGH = 2'd2
   } seg_t;

   localparam int LOW_EXTRA  = 7;
   localparam int HIGH_EXTRA = 5;

endpackage

// File: rtl/scl_tick_div.sv
module scl_tick_div #(
   parameter int PSC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             bypass_i,
   input  logic [PSC_W-1:0] presc_i,
   output logic             tick_o
);

   logic [PSC_W-1:0] pcnt_q;

   assign tick_o = en_i & (bypass_i | (pcnt_q >= presc_i));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pcnt_q <= '0;
      else if (!en_i || tick_o)
         pcnt_q <= '0;
      else
         pcnt_q <= pcnt_q + PSC_W'(1);
   end

   // R1: with a nonzero prescaler and no bypass, ticks are never back to back
   assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && presc_i != '0 && !bypass_i) |=> (!tick_o || presc_i == '0 || bypass_i));

endmodule

// File: rtl/scl_field_sel.sv
module scl_field_sel
   import scl_gen_pkg::*;
#(
   parameter int FIELD_W = 8,
   parameter int CNT_W   = FIELD_W + 1
) (
   input  logic [2*FIELD_W-1:0] low_cfg_i,
   input  logic [2*FIELD_W-1:0] high_cfg_i,
   input  logic                 hs_sel_i,
   output logic [CNT_W-1:0]     low_len_o,
   output logic [CNT_W-1:0]     high_len_o
);

   logic [FIELD_W-1:0] low_fld, high_fld;

   always_comb begin
      if (hs_sel_i) begin
         low_fld  = low_cfg_i[2*FIELD_W-1:FIELD_W];
         high_fld = high_cfg_i[2*FIELD_W-1:FIELD_W];
      end else begin
         low_fld  = low_cfg_i[FIELD_W-1:0];
         high_fld = high_cfg_i[FIELD_W-1:0];
      end
      low_len_o  = CNT_W'(low_fld)  + CNT_W'(LOW_EXTRA);
      high_len_o = CNT_W'(high_fld) + CNT_W'(HIGH_EXTRA);
   end

endmodule

// File: rtl/scl_phase_ctl.sv
module scl_phase_ctl #(
   parameter bit HS_SUPPORT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic hs_en_i,
   input  logic hs_go_i,
   output logic phase2_o
);

   generate
      if (HS_SUPPORT) begin : g_hs
         logic phase2_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               phase2_q <= 1'b0;
            else if (!run_i || !hs_en_i)
               phase2_q <= 1'b0;
            else if (hs_go_i)
               phase2_q <= 1'b1;
         end
         assign phase2_o = phase2_q;

         // R4: leaving run or high-speed operation drops back to phase one
         assert_phase_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_i || !hs_en_i) |=> !phase2_o);
      end else begin : g_no_hs
         logic unused_in;
         assign unused_in = clk ^ rst_n ^ run_i ^ hs_en_i ^ hs_go_i;
         assign phase2_o  = 1'b0 & unused_in;
      end
   endgenerate

endmodule

// File: rtl/scl_seg_fsm.sv
module scl_seg_fsm
   import scl_gen_pkg::*;
#(
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             tick_i,
   input  logic             phase2_i,
   input  logic [CNT_W-1:0] low_len_i,
   input  logic [CNT_W-1:0] high_len_i,
   output logic             busy_o,
   output logic             seg_hs_o,
   output logic             scl_o,
   output logic             change_o,
   output logic             sample_o
);

   seg_t             seg_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lat_low_q, lat_high_q;
   logic             seg_hs_q;
   logic             fall_q;
   logic             low_done, high_done;

   assign low_done  = tick_i && (cnt_q == lat_low_q  - CNT_W'(1));
   assign high_done = tick_i && (cnt_q == lat_high_q - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seg_q      <= SEG_IDLE;
         cnt_q      <= '0;
         lat_low_q  <= '0;
         lat_high_q <= '0;
         seg_hs_q   <= 1'b0;
         fall_q     <= 1'b0;
      end else begin
         fall_q <= 1'b0;
         if (!run_i) begin
            seg_q    <= SEG_IDLE;
            cnt_q    <= '0;
            seg_hs_q <= 1'b0;
         end else begin
            unique case (seg_q)
               SEG_IDLE: begin
                  seg_q      <= SEG_LOW;
                  cnt_q      <= '0;
                  lat_low_q  <= low_len_i;
                  lat_high_q <= high_len_i;
                  seg_hs_q   <= phase2_i;
                  fall_q     <= 1'b1;
               end
               SEG_LOW: begin
                  if (low_done) begin
                     seg_q <= SEG_HIGH;
                     cnt_q <= '0;
                  end else if (tick_i) begin
                     cnt_q <= cnt_q + CNT_W'(1);
                  end
               end
               SEG_HIGH: begin
                  if (high_done) begin
                     seg_q      <= SEG_LOW;
                     cnt_q      <= '0;
                     lat_low_q  <= low_len_i;
                     lat_high_q <= high_len_i;
                     seg_hs_q   <= phase2_i;
                     fall_q     <= 1'b1;
                  end else if (tick_i) begin
                     cnt_q <= cnt_q + CNT_W'(1);
                  end
               end
               default: seg_q <= SEG_IDLE;
            endcase
         end
      end
   end

   assign busy_o   = (seg_q != SEG_IDLE);
   assign seg_hs_o = seg_hs_q;
   assign scl_o    = (seg_q != SEG_LOW);
   assign change_o = fall_q;
   assign sample_o = (seg_q == SEG_HIGH) && tick_i && (cnt_q == (lat_high_q >> 1));

   // R2: the low tick count never passes the latched low length
   assert_low_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_q == SEG_LOW) |-> (cnt_q < lat_low_q));
   // R3: the high tick count never passes the latched high length
   assert_high_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_q == SEG_HIGH) |-> (cnt_q < lat_high_q));
   // R5: a stop request releases SCL on the next cycle
   assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> scl_o);
   // R7: every falling edge carries the change strobe
   assert_change_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(scl_o) |-> change_o);
   // R7: sampling only happens while SCL is high
   assert_sample_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sample_o |-> scl_o);
   // R8: latched lengths move only at the start of a low period
   assert_latch_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(lat_low_q) |-> change_o);
   assert_latch_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(lat_high_q) |-> change_o);

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
   import scl_gen_pkg::*;
#(
   parameter int PSC_W      = 8,
   parameter int FIELD_W    = 8,
   parameter bit HS_SUPPORT = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [PSC_W-1:0]     presc_i,
   input  logic [2*FIELD_W-1:0] low_cfg_i,
   input  logic [2*FIELD_W-1:0] high_cfg_i,
   input  logic                 hs_en_i,
   input  logic                 run_i,
   input  logic                 hs_go_i,
   output logic                 scl_o,
   output logic                 tick_o,
   output logic                 sample_o,
   output logic                 change_o
);

   localparam int CNT_W = FIELD_W + 1;

   generate
      if (PSC_W < 1) begin : g_bad_psc
         $error("scl_timing_gen: PSC_W must be at least 1");
      end
      if (FIELD_W < 3) begin : g_bad_field
         $error("scl_timing_gen: FIELD_W must be at least 3 to hold the fixed extras");
      end
   endgenerate

   logic             phase2;
   logic             busy, seg_hs;
   logic [CNT_W-1:0] low_len, high_len;

   scl_phase_ctl #(.HS_SUPPORT(HS_SUPPORT)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (run_i),
      .hs_en_i  (hs_en_i),
      .hs_go_i  (hs_go_i),
      .phase2_o (phase2)
   );

   scl_field_sel #(.FIELD_W(FIELD_W), .CNT_W(CNT_W)) u_sel (
      .low_cfg_i  (low_cfg_i),
      .high_cfg_i (high_cfg_i),
      .hs_sel_i   (phase2),
      .low_len_o  (low_len),
      .high_len_o (high_len)
   );

   scl_tick_div #(.PSC_W(PSC_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (busy & run_i),
      .bypass_i (seg_hs),
      .presc_i  (presc_i),
      .tick_o   (tick_o)
   );

   scl_seg_fsm #(.CNT_W(CNT_W)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_i      (run_i),
      .tick_i     (tick_o),
      .phase2_i   (phase2),
      .low_len_i  (low_len),
      .high_len_i (high_len),
      .busy_o     (busy),
      .seg_hs_o   (seg_hs),
      .scl_o      (scl_o),
      .change_o   (change_o),
      .sample_o   (sample_o)
   );

   // R6: in the second high-speed phase the tick fires on every running cycle
   assert_hs_every_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_hs && busy && run_i) |-> tick_o);

endmodule

// File: tb/scl_timing_gen_test.sv
module scl_timing_gen_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  presc_i = '0;
   logic [15:0] low_cfg_i = '0;
   logic [15:0] high_cfg_i = '0;
   logic        hs_en_i = 1'b0;
   logic        run_i = 1'b0;
   logic        hs_go_i = 1'b0;
   logic        scl_o, tick_o, sample_o, change_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   scl_timing_gen uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .presc_i    (presc_i),
      .low_cfg_i  (low_cfg_i),
      .high_cfg_i (high_cfg_i),
      .hs_en_i    (hs_en_i),
      .run_i      (run_i),
      .hs_go_i    (hs_go_i),
      .scl_o      (scl_o),
      .tick_o     (tick_o),
      .sample_o   (sample_o),
      .change_o   (change_o)
   );

   // waveform monitor, sampled away from the active edge
   int cyc = 0, fall_t = 0, rise_t = 0, lo_len = 0, hi_len = 0;
   int nfall = 0, nrise = 0, nchg = 0, nchg_fall = 0;
   int samp_off = -1, nsamp = 0, tick_cnt = 0, last_tick = 0, tick_gap = 0;
   logic prev_scl = 1'b1;

   always @(negedge clk) begin
      cyc++;
      if (prev_scl && !scl_o) begin
         hi_len = cyc - rise_t;
         fall_t = cyc;
         nfall++;
         if (change_o) nchg_fall++;
      end
      if (!prev_scl && scl_o) begin
         lo_len = cyc - fall_t;
         rise_t = cyc;
         nrise++;
      end
      if (change_o) nchg++;
      if (sample_o) begin
         samp_off = cyc - rise_t;
         nsamp++;
      end
      if (tick_o) begin
         tick_gap = cyc - last_tick;
         last_tick = cyc;
         tick_cnt++;
      end
      prev_scl = scl_o;
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wait_fall();
      int n = nfall;
      wait (nfall == n + 1);
   endtask

   task automatic wait_rise();
      int n = nrise;
      wait (nrise == n + 1);
   endtask

   // measures the period that begins at the next falling edge
   task automatic measure_next(output int lo, output int hi);
      wait_fall();
      wait_rise();
      lo = lo_len;
      wait_fall();
      hi = hi_len;
   endtask

   // measures the period already under way (call while SCL is low)
   task automatic measure_cur(output int lo, output int hi);
      wait_rise();
      lo = lo_len;
      wait_fall();
      hi = hi_len;
   endtask

   task automatic restart(input int p, input int lcfg, input int hcfg, input bit hs);
      run_i = 1'b0;
      repeat (3) @(negedge clk);
      presc_i    = 8'(p);
      low_cfg_i  = 16'(lcfg);
      high_cfg_i = 16'(hcfg);
      hs_en_i    = hs;
      run_i      = 1'b1;
   endtask

   task automatic pulse_go();
      hs_go_i = 1'b1;
      @(negedge clk);
      hs_go_i = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R9", "scl under reset", int'(scl_o), 1);
      chk("R9", "tick under reset", int'(tick_o), 0);
      chk("R9", "change under reset", int'(change_o), 0);
      chk("R9", "sample under reset", int'(sample_o), 0);
   endtask

   task automatic t_basic();
      int lo, hi;
      restart(3, 16'h0002, 16'h0001, 1'b0);
      measure_next(lo, hi);
      chk("R2", "low P3 L2", lo, 9 * 4);
      chk("R3", "high P3 H1", hi, 6 * 4);
      chk("R1", "tick gap P3", tick_gap, 4);
      chk("R7", "sample offset P3 H1", samp_off, 3 * 4 + 3);
   endtask

   task automatic t_zero();
      int lo, hi;
      restart(0, 16'hFF00, 16'hFF00, 1'b0);
      measure_next(lo, hi);
      chk("R2", "low all-zero field", lo, 7);
      chk("R3", "high all-zero field", hi, 5);
      chk("R1", "tick gap P0", tick_gap, 1);
      chk("R7", "sample offset zero field", samp_off, 2);
   endtask

   task automatic t_hs();
      int lo, hi;
      restart(2, 16'h030A, 16'h0206, 1'b1);
      measure_next(lo, hi);
      chk("R4", "phase one low uses bits 7:0", lo, 17 * 3);
      chk("R4", "phase one high uses bits 7:0", hi, 11 * 3);
      pulse_go();
      measure_next(lo, hi);
      chk("R6", "phase two low bypasses prescaler", lo, 10);
      chk("R6", "phase two high bypasses prescaler", hi, 7);
      chk("R6", "phase two tick gap", tick_gap, 1);
      chk("R7", "phase two sample offset", samp_off, 3);
      restart(2, 16'h030A, 16'h0206, 1'b1);
      measure_next(lo, hi);
      chk("R4", "stop returns to phase one low", lo, 17 * 3);
      chk("R4", "stop returns to phase one high", hi, 11 * 3);
   endtask

   task automatic t_go_ignored();
      int lo, hi;
      restart(1, 16'h0904, 16'h0902, 1'b0);
      measure_next(lo, hi);
      pulse_go();
      measure_next(lo, hi);
      chk("R4", "strobe ignored low", lo, 22);
      chk("R4", "strobe ignored high", hi, 14);
      chk("R1", "tick gap P1", tick_gap, 2);
   endtask

   task automatic t_update();
      int lo, hi;
      restart(1, 16'h0004, 16'h0002, 1'b0);
      measure_next(lo, hi);
      low_cfg_i  = 16'h0008;
      high_cfg_i = 16'h0006;
      measure_cur(lo, hi);
      chk("R8", "current low keeps old word", lo, 22);
      chk("R8", "current high keeps old word", hi, 14);
      measure_cur(lo, hi);
      chk("R8", "next low uses new word", lo, 30);
      chk("R8", "next high uses new word", hi, 22);
   endtask

   task automatic t_stop();
      int lo, hi, tk, ch, sm;
      restart(1, 16'h0005, 16'h0003, 1'b0);
      wait_fall();
      repeat (5) @(negedge clk);
      run_i = 1'b0;
      @(negedge clk);
      chk("R5", "scl released one cycle after stop", int'(scl_o), 1);
      tk = tick_cnt;
      ch = nchg;
      sm = nsamp;
      repeat (20) @(negedge clk);
      chk("R5", "scl stays high while stopped", int'(scl_o), 1);
      chk("R5", "no ticks while stopped", tick_cnt, tk);
      chk("R5", "no change strobes while stopped", nchg, ch);
      chk("R5", "no sample strobes while stopped", nsamp, sm);
      run_i = 1'b1;
      measure_cur(lo, hi);
      chk("R5", "restart gives full low", lo, 12 * 2);
      chk("R5", "restart high", hi, 8 * 2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_basic();
      t_zero();
      t_hs();
      t_go_ignored();
      t_update();
      t_stop();
      run_i = 1'b0;
      repeat (3) @(negedge clk);
      chk("R7", "one change strobe per falling edge", nchg, nfall);
      chk("R7", "change strobe on falling-edge cycle", nchg_fall, nfall);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule